// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block connects an A bus and a B bus that are 16 bits wide. It is built as two independent 8-bit sections. Each section has two storage banks, one for each direction of transfer. A bank is a row of D-type latch cells with a flow-through bypass. A-to-B transfers have their own chip enable, latch enable and output enable, and so do B-to-A transfers. All of these controls are active low, and every section has its own full set of them.

A latch bank is transparent only when its chip enable and its latch enable are both low. While it is transparent, the value on the far port follows the near port in the same cycle. When the latch enable rises, or the chip enable rises, the bank stops loading. It then holds the value it took at the last clock edge at which it was transparent.

A port is driven only when the chip enable and the output enable of its direction are both low. Each port is modelled as a split triple: an input vector, an output vector and a per-bit drive enable. An undriven port reads as zero on the output vector, with its drive enable low. The value driven on the A side comes only from the B-to-A bank, and the value driven on the B side comes only from the A-to-B bank. The clock sets when a bank loads; the reset clears every bank to zero.

Top module: `xcvr_dual`

## Requirements
- R1: After reset, every bank holds zero. Enabling an output with its latch enable high shows 0x00 on that section's port.
- R2: While a bank's chip enable and latch enable are both low, the opposite port shows the near input in the same cycle. For example, b_out equals a_in.
- R3: Once the latch enable is high, the bank keeps the value it loaded at the last clock edge at which it was transparent. Later changes on the near input do not change the output.
- R4: A high chip enable with a low latch enable also stops loading. The stored value survives, exactly as if the latch enable had risen.
- R5: A port's drive-enable bits are all 1 only when the chip enable and the output enable of that direction are both low. Otherwise they are all 0, and the output vector is 0x00.
- R6: B-to-A transfer follows R2 to R5 using the B-to-A controls, a_out and a_oe, and a separate bank.
- R7: Control or data activity on one 8-bit section leaves the other section's outputs and stored values unchanged.
- R8: With both directions transparent and driven, b_out equals a_in and a_out equals b_in. Neither port's output reflects its own input.
- R9: A bank loads while its output is disabled (chip enable low, latch enable low, output enable high). The loaded value appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; banks load on the rising edge while transparent |
| rst_n | input | 1 | Asynchronous active-low reset, clears all banks |
| a_in | input | 16 | Value present on the A bus |
| b_in | input | 16 | Value present on the B bus |
| ab_ce_n | input | 2 | A-to-B chip enable, one bit per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable, one bit per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable, one bit per section, active low |
| ba_ce_n | input | 2 | B-to-A chip enable, one bit per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable, one bit per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable, one bit per section, active low |
| a_out | output | 16 | Value driven onto the A bus, zero when not driven |
| a_oe | output | 16 | Per-bit drive enable for the A bus |
| b_out | output | 16 | Value driven onto the B bus, zero when not driven |
| b_oe | output | 16 | Per-bit drive enable for the B bus |

## Verification
Both directions of one section can be transparent and driven in the same cycle. This is the state in which a wrong connection would loop a port back onto itself. The bench provokes it by opening both banks of section 0 with different values on a_in and b_in. It requires that each port carry only the opposite input, and that each bank, once closed, hold its own captured byte. Section 1 is busy at the same time as section 0 in the cross-section test, and its outputs are judged cycle by cycle against the byte it stored earlier.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // One direction's control set, all active low.
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } dir_ctl_t;

   function automatic logic ctl_loads(dir_ctl_t c);
      return !c.ce_n && !c.le_n;
   endfunction

   function automatic logic ctl_drives(dir_ctl_t c);
      return !c.ce_n && !c.oe_n;
   endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
   import xcvr_pkg::*;
#(
   parameter int W          = 8,
   parameter bit FLOW_BYPASS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  dir_ctl_t     ctl,
   output logic [W-1:0] dout,
   output logic [W-1:0] drv
);

   initial begin
      assert (W > 0) else $error("bank width must be positive");
   end

   logic         xparent;
   logic         drive_on;
   logic [W-1:0] held_q;
   logic [W-1:0] cell_val;

   assign xparent  = ctl_loads(ctl);
   assign drive_on = ctl_drives(ctl);

   // Storage cells: load on the clock while the bank is open.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= '0;
      else if (xparent) held_q <= din;
   end

   generate
      if (FLOW_BYPASS) begin : g_bypass
         // An open bank passes the live input straight through.
         assign cell_val = xparent ? din : held_q;

         assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (xparent && drive_on) |-> (dout == din));
      end else begin : g_regonly
         assign cell_val = held_q;
      end
   endgenerate

   assign drv  = {W{drive_on}};
   assign dout = drive_on ? cell_val : '0;

   // R3/R4: a closed bank does not change its driven value.
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xparent && $past(!xparent) && drive_on && $past(drive_on)) |-> $stable(dout));

   // R5: an undriven port carries zero and no drive bits.
   assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_on |-> (dout == '0 && drv == '0));

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
   import xcvr_pkg::*;
#(
   parameter int W           = 8,
   parameter bit FLOW_BYPASS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  dir_ctl_t     ab_ctl,
   input  dir_ctl_t     ba_ctl,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   // A side feeds the bank that drives B.
   xcvr_latch_bank #(.W(W), .FLOW_BYPASS(FLOW_BYPASS)) u_ab_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (a_in),
      .ctl  (ab_ctl),
      .dout (b_out),
      .drv  (b_oe)
   );

   // B side feeds the bank that drives A.
   xcvr_latch_bank #(.W(W), .FLOW_BYPASS(FLOW_BYPASS)) u_ba_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (b_in),
      .ctl  (ba_ctl),
      .dout (a_out),
      .drv  (a_oe)
   );

   // R8: with both directions open and driven, no port echoes itself.
   assert_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_loads(ab_ctl) && ctl_drives(ab_ctl) && ctl_loads(ba_ctl) && ctl_drives(ba_ctl)
       && FLOW_BYPASS) |-> (b_out == a_in && a_out == b_in));

endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual
   import xcvr_pkg::*;
#(
   parameter int SECT_W      = 8,
   parameter int NUM_SECT    = 2,
   parameter bit FLOW_BYPASS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SECT_W*NUM_SECT-1:0] a_in,
   input  logic [SECT_W*NUM_SECT-1:0] b_in,
   input  logic [NUM_SECT-1:0]        ab_ce_n,
   input  logic [NUM_SECT-1:0]        ab_le_n,
   input  logic [NUM_SECT-1:0]        ab_oe_n,
   input  logic [NUM_SECT-1:0]        ba_ce_n,
   input  logic [NUM_SECT-1:0]        ba_le_n,
   input  logic [NUM_SECT-1:0]        ba_oe_n,
   output logic [SECT_W*NUM_SECT-1:0] a_out,
   output logic [SECT_W*NUM_SECT-1:0] a_oe,
   output logic [SECT_W*NUM_SECT-1:0] b_out,
   output logic [SECT_W*NUM_SECT-1:0] b_oe
);

   localparam int BUS_W = SECT_W * NUM_SECT;

   initial begin
      assert (SECT_W > 0)   else $error("section width must be positive");
      assert (NUM_SECT > 0) else $error("need at least one section");
      assert (BUS_W <= 1024) else $error("bus width out of range");
   end

   generate
      for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
         dir_ctl_t ab_c;
         dir_ctl_t ba_c;

         assign ab_c = '{ce_n: ab_ce_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
         assign ba_c = '{ce_n: ba_ce_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

         xcvr_section #(.W(SECT_W), .FLOW_BYPASS(FLOW_BYPASS)) u_sect (
            .clk   (clk),
            .rst_n (rst_n),
            .a_in  (a_in[s*SECT_W +: SECT_W]),
            .b_in  (b_in[s*SECT_W +: SECT_W]),
            .ab_ctl(ab_c),
            .ba_ctl(ba_c),
            .a_out (a_out[s*SECT_W +: SECT_W]),
            .a_oe  (a_oe[s*SECT_W +: SECT_W]),
            .b_out (b_out[s*SECT_W +: SECT_W]),
            .b_oe  (b_oe[s*SECT_W +: SECT_W])
         );

         // R7: a section whose own inputs and controls are frozen keeps its outputs.
         assert_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(a_in[s*SECT_W +: SECT_W]) && $stable(b_in[s*SECT_W +: SECT_W])
             && $stable(ab_c) && $stable(ba_c) && ab_le_n[s] && ba_le_n[s])
            |-> ($stable(b_out[s*SECT_W +: SECT_W]) && $stable(a_out[s*SECT_W +: SECT_W])));
      end
   endgenerate

endmodule

// File: tb/xcvr_dual_tb.sv
module xcvr_dual_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] a_in, b_in;
   logic [1:0]  ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
   logic [15:0] a_out, a_oe, b_out, b_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   xcvr_dual u_dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   // Layout: ctl{ab_ce,ab_le,ab_oe,ba_ce,ba_le,ba_oe}[39:34] a[33:26] b[25:18]
   //         exp_b[17:10] exp_boe[9] exp_a[8:1] exp_aoe[0]  (section 0 only)
   localparam int NV = 12;
   localparam logic [39:0] VEC [NV] = '{
      {6'b000111, 8'h3C, 8'h00, 8'h3C, 1'b1, 8'h00, 1'b0}, // R2
      {6'b000111, 8'h5A, 8'h00, 8'h5A, 1'b1, 8'h00, 1'b0}, // R2
      {6'b010111, 8'hFF, 8'h00, 8'h5A, 1'b1, 8'h00, 1'b0}, // R3
      {6'b010111, 8'h00, 8'h00, 8'h5A, 1'b1, 8'h00, 1'b0}, // R3
      {6'b011111, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R5
      {6'b010111, 8'h00, 8'h00, 8'h5A, 1'b1, 8'h00, 1'b0}, // R5
      {6'b001111, 8'h81, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R9
      {6'b100111, 8'h99, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R4
      {6'b010111, 8'h99, 8'h00, 8'h81, 1'b1, 8'h00, 1'b0}, // R4 R9
      {6'b010000, 8'h99, 8'hC3, 8'h81, 1'b1, 8'hC3, 1'b1}, // R6
      {6'b000000, 8'h12, 8'h34, 8'h12, 1'b1, 8'h34, 1'b1}, // R8
      {6'b010010, 8'h55, 8'h77, 8'h12, 1'b1, 8'h34, 1'b1}  // R8 R3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_sec(input int s, input logic [5:0] c);
      {ab_ce_n[s], ab_le_n[s], ab_oe_n[s], ba_ce_n[s], ba_le_n[s], ba_oe_n[s]} = c;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      a_in = '0; b_in = '0;
      set_sec(0, 6'b111111);
      set_sec(1, 6'b111111);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: outputs enabled, latches closed, show the cleared contents.
      @(posedge clk); #1;
      a_in = 16'hFFFF; b_in = 16'hFFFF;
      set_sec(0, 6'b010010);
      set_sec(1, 6'b010010);
      @(negedge clk);
      chk("R1 b_out", b_out, 16'h0000);
      chk("R1 a_out", a_out, 16'h0000);
      chk("R1 b_oe",  b_oe,  16'hFFFF);
      chk("R1 a_oe",  a_oe,  16'hFFFF);
      @(posedge clk); #1;
      set_sec(1, 6'b111111);
      a_in = '0; b_in = '0;

      // Vector walk over section 0; section 1 stays disabled.
      for (int i = 0; i < NV; i++) begin
         set_sec(0, VEC[i][39:34]);
         a_in[7:0] = VEC[i][33:26];
         b_in[7:0] = VEC[i][25:18];
         @(negedge clk);
         chk($sformatf("R2-9 vec%0d b_out", i), b_out[7:0], VEC[i][17:10]);
         chk($sformatf("R5 vec%0d b_oe",    i), b_oe[7:0],  {8{VEC[i][9]}});
         chk($sformatf("R6 vec%0d a_out",   i), a_out[7:0], VEC[i][8:1]);
         chk($sformatf("R6 vec%0d a_oe",    i), a_oe[7:0],  {8{VEC[i][0]}});
         chk($sformatf("R7 vec%0d hi",      i), {b_out[15:8], b_oe[15:8], a_out[15:8], a_oe[15:8]}, 32'h0);
         @(posedge clk); #1;
      end

      // R7: load section 1, then run section 0 hard while section 1 holds.
      set_sec(0, 6'b111111);
      set_sec(1, 6'b000111);
      a_in[15:8] = 8'hE7;
      @(posedge clk); #1;
      set_sec(1, 6'b010111);
      a_in[15:8] = 8'h00;
      @(negedge clk);
      chk("R3 sec1 hold", b_out[15:8], 8'hE7);
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #1;
         set_sec(0, (k % 2 == 0) ? 6'b000000 : 6'b111111);
         a_in[7:0] = 8'(k * 8'h11 + 8'h01);
         b_in[7:0] = 8'(8'hF0 - k);
         @(negedge clk);
         chk("R7 sec1 b_out", b_out[15:8], 8'hE7);
         chk("R7 sec1 b_oe",  b_oe[15:8],  8'hFF);
         chk("R7 sec1 a_out", a_out[15:8], 8'h00);
         if (k % 2 == 0) chk("R7 sec0 live", b_out[7:0], 8'(k * 8'h11 + 8'h01));
      end

      // R7 reverse: section 0 holds while section 1 opens both ways.
      @(posedge clk); #1;
      set_sec(0, 6'b000111);
      a_in[7:0] = 8'hA5;
      @(posedge clk); #1;
      set_sec(0, 6'b010111);
      set_sec(1, 6'b000000);
      a_in = 16'h6600; b_in = 16'h9900;
      @(negedge clk);
      chk("R7 sec0 hold", b_out[7:0], 8'hA5);
      chk("R8 sec1 b", b_out[15:8], 8'h66);
      chk("R8 sec1 a", a_out[15:8], 8'h99);

      // R4: chip enable released with latch enable still low.
      @(posedge clk); #1;
      set_sec(1, 6'b100111);
      a_in[15:8] = 8'h3E;
      @(posedge clk); #1;
      set_sec(1, 6'b010111);
      @(negedge clk);
      chk("R4 sec1 kept", b_out[15:8], 8'h66);

      finish_run();
   end

endmodule